// File: doc/BRIEF.md
# Bit-Sliced Integer ALU with Carry and Overflow Flags

This block is a purely combinational 32-bit integer arithmetic/logic unit. It takes two operands and a 3-bit operation code. It returns a 32-bit result, a carry-out flag and a signed-overflow flag. Six operations are provided: bitwise AND and OR, and add and subtract, each in a signed and an unsigned form. The signed and unsigned forms produce the same result and carry bits. They differ only in whether the overflow flag may be raised.

The datapath is one 1-bit slice replicated once per bit. Each slice holds three parts:
- an AND/OR logic part,
- a full adder whose B input can be inverted by an XOR,
- a result multiplexer.

The carry ripples from each slice into the one above it. Subtraction is formed by inverting B and forcing the carry into the lowest slice to 1. Signed overflow is the XOR of the carry entering the top slice and the carry leaving it. A small decoder turns the operation code into the slice controls.

Top module: `bitslice_alu`

## Requirements
- R1: Operation code 000 gives result = A AND B, bit by bit.
- R2: Operation code 001 gives result = A OR B, bit by bit.
- R3: Operation code 010 (signed add) gives result = (A + B) mod 2^32, and carry_out = bit 32 of the 33-bit unsigned sum.
- R4: Operation code 011 (unsigned add) gives the same result and carry_out as R3, with overflow = 0.
- R5: Operation code 110 (signed subtract) gives result = (A - B) mod 2^32, and carry_out = bit 32 of A + (NOT B) + 1 (which is 1 exactly when A >= B unsigned).
- R6: Operation code 111 (unsigned subtract) gives the same result and carry_out as R5, with overflow = 0.
- R7: For code 010, overflow = 1 exactly when A and B have the same sign bit (bit 31) and the result's sign bit differs from it.
- R8: For code 110, overflow = 1 exactly when the sign bits of A and B differ and the result's sign bit differs from that of A.
- R9: For codes 000 and 001, carry_out = 0 and overflow = 0.
- R10: Codes 100 and 101 are unused; they drive result = 0, carry_out = 0 and overflow = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| op_sel | input | 3 | Operation code |
| result | output | 32 | Selected result |
| carry_out | output | 1 | Carry out of the top slice (arithmetic only) |
| overflow | output | 1 | Signed overflow (signed add/subtract only) |

## Verification
Directed operands target the points where the flags change:
- Most-positive plus one, and most-negative plus most-negative, separate signed overflow from unsigned carry in both directions.
- All-ones plus one ripples a carry through every slice.
- Zero minus one, most-negative minus one, and equal operands tell the borrow behaviour of subtract apart from its overflow.

Random operands are spread over all eight codes. They show that the signed and unsigned forms differ only in the overflow flag, and that the unused codes stay silent whatever the operands are.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [2:0] {
        OPC_AND  = 3'b000,
        OPC_OR   = 3'b001,
        OPC_ADD  = 3'b010,
        OPC_ADDU = 3'b011,
        OPC_NU4  = 3'b100,
        OPC_NU5  = 3'b101,
        OPC_SUB  = 3'b110,
        OPC_SUBU = 3'b111
    } alu_opc_e;

    typedef enum logic [1:0] {
        PICK_AND  = 2'd0,
        PICK_OR   = 2'd1,
        PICK_SUM  = 2'd2,
        PICK_ZERO = 2'd3
    } slice_pick_e;

    typedef struct packed {
        logic        invert_b;
        logic        carry_seed;
        logic        is_arith;
        logic        is_signed;
        slice_pick_e pick;
    } alu_ctrl_t;

endpackage

// File: rtl/alu_decode.sv
module alu_decode
    import alu_pkg::*;
(
    input  logic [2:0] op_sel,
    output alu_ctrl_t  ctrl
);

    alu_opc_e opc;
    assign opc = alu_opc_e'(op_sel);

    always_comb begin
        ctrl = '{invert_b: 1'b0, carry_seed: 1'b0, is_arith: 1'b0,
                 is_signed: 1'b0, pick: PICK_ZERO};
        unique case (opc)
            OPC_AND:  ctrl.pick = PICK_AND;
            OPC_OR:   ctrl.pick = PICK_OR;
            OPC_ADD: begin
                ctrl.pick      = PICK_SUM;
                ctrl.is_arith  = 1'b1;
                ctrl.is_signed = 1'b1;
            end
            OPC_ADDU: begin
                ctrl.pick     = PICK_SUM;
                ctrl.is_arith = 1'b1;
            end
            OPC_SUB: begin
                ctrl.pick       = PICK_SUM;
                ctrl.is_arith   = 1'b1;
                ctrl.is_signed  = 1'b1;
                ctrl.invert_b   = 1'b1;
                ctrl.carry_seed = 1'b1;
            end
            OPC_SUBU: begin
                ctrl.pick       = PICK_SUM;
                ctrl.is_arith   = 1'b1;
                ctrl.invert_b   = 1'b1;
                ctrl.carry_seed = 1'b1;
            end
            OPC_NU4, OPC_NU5: ctrl.pick = PICK_ZERO;
            default:          ctrl.pick = PICK_ZERO;
        endcase
    end

    // R10: an unused code never enables the adder path
    always_comb begin
        if (op_sel[2:1] == 2'b10)
            a_r10_unused_no_arith: assert (!ctrl.is_arith && ctrl.pick == PICK_ZERO);
    end

endmodule

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
    import alu_pkg::*;
(
    input  logic        a_bit,
    input  logic        b_bit,
    input  logic        c_in,
    input  logic        invert_b,
    input  slice_pick_e pick,
    output logic        r_bit,
    output logic        c_out
);

    logic b_eff;
    logic and_o;
    logic or_o;
    logic sum_o;

    assign b_eff = b_bit ^ invert_b;
    assign and_o = a_bit & b_bit;
    assign or_o  = a_bit | b_bit;
    assign sum_o = a_bit ^ b_eff ^ c_in;
    assign c_out = (a_bit & b_eff) | (a_bit & c_in) | (b_eff & c_in);

    always_comb begin
        unique case (pick)
            PICK_AND:  r_bit = and_o;
            PICK_OR:   r_bit = or_o;
            PICK_SUM:  r_bit = sum_o;
            PICK_ZERO: r_bit = 1'b0;
            default:   r_bit = 1'b0;
        endcase
    end

endmodule

// File: rtl/bitslice_alu.sv
module bitslice_alu
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic [2:0]       op_sel,
    output logic [WIDTH-1:0] result,
    output logic             carry_out,
    output logic             overflow
);

    localparam int MSB = WIDTH - 1;

    alu_ctrl_t      ctrl;
    logic [WIDTH:0] chain;

    alu_decode u_dec (
        .op_sel (op_sel),
        .ctrl   (ctrl)
    );

    assign chain[0] = ctrl.carry_seed;

    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        alu_bit_slice u_slice (
            .a_bit    (opnd_a[i]),
            .b_bit    (opnd_b[i]),
            .c_in     (chain[i]),
            .invert_b (ctrl.invert_b),
            .pick     (ctrl.pick),
            .r_bit    (result[i]),
            .c_out    (chain[i+1])
        );
    end

    assign carry_out = ctrl.is_arith & chain[WIDTH];
    assign overflow  = ctrl.is_signed & (chain[MSB] ^ chain[WIDTH]);

    always_comb begin
        // R9: logic codes raise no flag
        if (op_sel[2:1] == 2'b00)
            a_r9_logic_no_flags: assert (!carry_out && !overflow);
        // R10: unused codes are silent
        if (op_sel[2:1] == 2'b10)
            a_r10_unused_zero: assert (result == '0 && !carry_out && !overflow);
        // R4 / R6: unsigned forms never flag overflow
        if (op_sel == 3'b011 || op_sel == 3'b111)
            a_r4_unsigned_no_overflow: assert (!overflow);
        // R7: signed add overflow only with like signs and a flipped result sign
        if (op_sel == 3'b010 && overflow)
            a_r7_add_sign_rule: assert (opnd_a[MSB] == opnd_b[MSB] && result[MSB] != opnd_a[MSB]);
        // R8: signed subtract overflow only with unlike signs and a flipped result sign
        if (op_sel == 3'b110 && overflow)
            a_r8_sub_sign_rule: assert (opnd_a[MSB] != opnd_b[MSB] && result[MSB] != opnd_a[MSB]);
    end

endmodule

// File: tb/tb_bitslice_alu.sv
`timescale 1ns/1ps
module tb_bitslice_alu;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] a, b;
    logic [2:0]  op;
    logic [31:0] result;
    logic        carry_out, overflow;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    bitslice_alu dut (
        .opnd_a    (a),
        .opnd_b    (b),
        .op_sel    (op),
        .result    (result),
        .carry_out (carry_out),
        .overflow  (overflow)
    );

    function automatic logic [33:0] model(input logic [31:0] x, input logic [31:0] y,
                                          input logic [2:0] code);
        logic [32:0] s;
        logic [31:0] r;
        logic c, v;
        r = '0; c = 1'b0; v = 1'b0;
        case (code)
            3'b000: r = x & y;
            3'b001: r = x | y;
            3'b010, 3'b011: begin
                s = {1'b0, x} + {1'b0, y};
                r = s[31:0]; c = s[32];
                if (code == 3'b010) v = (x[31] == y[31]) && (s[31] != x[31]);
            end
            3'b110, 3'b111: begin
                s = {1'b0, x} + {1'b0, ~y} + 33'd1;
                r = s[31:0]; c = s[32];
                if (code == 3'b110) v = (x[31] != y[31]) && (s[31] != x[31]);
            end
            default: r = '0;
        endcase
        return {c, v, r};
    endfunction

    function automatic string tag_of(input logic [2:0] code);
        case (code)
            3'b000:  return "R1/R9";
            3'b001:  return "R2/R9";
            3'b010:  return "R3/R7";
            3'b011:  return "R4";
            3'b110:  return "R5/R8";
            3'b111:  return "R6";
            default: return "R10";
        endcase
    endfunction

    task automatic apply(input logic [31:0] x, input logic [31:0] y, input logic [2:0] code);
        logic [33:0] e;
        @(negedge clk);
        a = x; b = y; op = code;
        #5;
        e = model(x, y, code);
        n_checks++;
        if ({carry_out, overflow, result} !== e) begin
            n_fail++;
            $display("FAIL %s op=%b a=%h b=%h: got c=%b v=%b r=%h, expected c=%b v=%b r=%h",
                     tag_of(code), code, x, y, carry_out, overflow, result, e[33], e[32], e[31:0]);
        end
    endtask

    initial begin
        a = '0; b = '0; op = 3'b000;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // reset-state check: idle inputs give zero outputs (R1/R9)
        apply(32'h0, 32'h0, 3'b000);
        // R1, R2 directed
        apply(32'hF0F0_A5A5, 32'h0FF0_FF00, 3'b000);
        apply(32'hF0F0_A5A5, 32'h0FF0_FF00, 3'b001);
        // R3/R7: signed overflow positive, negative; R4 same operands
        apply(32'h7FFF_FFFF, 32'h1, 3'b010);
        apply(32'h7FFF_FFFF, 32'h1, 3'b011);
        apply(32'h8000_0000, 32'h8000_0000, 3'b010);
        apply(32'h8000_0000, 32'h8000_0000, 3'b011);
        apply(32'hFFFF_FFFF, 32'h1, 3'b010);
        apply(32'hFFFF_FFFF, 32'h1, 3'b011);
        // R5/R8 and R6
        apply(32'h0, 32'h1, 3'b110);
        apply(32'h0, 32'h1, 3'b111);
        apply(32'h8000_0000, 32'h1, 3'b110);
        apply(32'h8000_0000, 32'h1, 3'b111);
        apply(32'h1234_5678, 32'h1234_5678, 3'b110);
        apply(32'h7FFF_FFFF, 32'hFFFF_FFFF, 3'b110);
        // R10 unused codes with busy operands
        apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'b100);
        apply(32'h8000_0000, 32'h8000_0000, 3'b101);
        // constrained random over all codes
        void'($urandom(32'd20240117));
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] x, y;
            x = $urandom();
            y = $urandom();
            if (i % 5 == 0) x[30:0] = (i % 2 == 0) ? 31'h7FFF_FFFF : 31'h0;
            if (i % 7 == 0) y = x;
            apply(x, y, 3'($urandom_range(0, 7)));
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule